// File: doc/BRIEF.md
# Programmable Minute/Second Countdown Watchdog

This block is a long-period watchdog. The host writes an 8-bit reload value through a small register bus and picks the size of one count: one second or one minute. A nonzero value starts the counter, which then counts down from that value. When the counter reaches zero it stops and raises a timeout status flag. The flag can drive an interrupt output, a reset output or both, each under its own enable. The host can also set or clear the flag directly at any time.

The timebase comes from an external one-second tick strobe. In minute mode an internal prescaler divides that tick by `MIN_DIV`. Three event strobes reload the counter with the last programmed value: a keyboard interrupt, a mouse interrupt, and a strobe from an external address decoder for I/O accesses to the service port. Each event has its own enable bit. Software or system activity keeps the watchdog from expiring by causing these reloads.

Top module: `lt_watchdog`

## Requirements
- R1: After a synchronous reset every register reads 0, the count is 0, and `timeout_o`, `irq_o` and `rst_o` are low.
- R2: A write of a nonzero value V to address 0 (LOAD) sets the count to V on that clock edge and starts counting. Each timebase unit then lowers the count by exactly one.
- R3: With CTRL (address 1) bit 0 clear, every `sec_tick` pulse is one timebase unit.
- R4: With CTRL bit 0 set, one timebase unit takes `MIN_DIV` tick pulses. A LOAD write or an accepted reload event restarts this division from zero.
- R5: The edge that takes the count from 1 to 0 also sets the status flag (address 2 bit 0, `timeout_o`). After that the count stays at 0 and further ticks do nothing.
- R6: A LOAD write of 0 makes the counter inactive. The count reads 0, ticks have no effect, and the status flag is not set by the write.
- R7: A write to address 2 copies data bit 0 into the status flag, whatever state the counter is in. This write overrides an expiry in the same cycle.
- R8: `evt_kbd`, `evt_mouse` and `evt_io` are enabled by CTRL bits 3, 4 and 5. An enabled event reloads the count with the LOAD value and restarts counting, even after the counter has stopped at zero. It does not change the status flag.
- R9: An event whose enable bit is clear leaves the count and the prescaler unchanged.
- R10: `irq_o` is high exactly when the status flag and CTRL bit 1 are both set. `rst_o` is high exactly when the status flag and CTRL bit 2 are both set.
- R11: `reg_rdata` returns, as a combinational function of `reg_addr`, the following: at address 0 the LOAD value, at address 1 CTRL with bits 7:6 reading 0, at address 2 the status flag in bit 0, and at address 3 the current count.
- R12: When several things happen in one cycle, a LOAD write wins over an event reload, and an event reload wins over a timebase unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sec_tick | input | 1 | One-cycle pulse once per second |
| evt_kbd | input | 1 | Keyboard interrupt event strobe |
| evt_mouse | input | 1 | Mouse interrupt event strobe |
| evt_io | input | 1 | Decoded I/O service-port access strobe |
| timeout_o | output | 1 | Timeout status flag |
| irq_o | output | 1 | Interrupt request |
| rst_o | output | 1 | Reset request |

## Verification
The assertions assume the following about the inputs: `sec_tick` and the event strobes are synchronous one-cycle-wide levels, and a register write lasts one cycle with stable address and data. The decrement and hold properties also rely on the LOAD and event inputs being the only other sources that change the count. The bench drives every input on the falling edge and keeps each write to a single cycle. It holds `sec_tick` high for exactly the number of rising edges a test wants counted, so every tick lands on a known edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        ADDR_LOAD   = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_STATUS = 2'd2,
        ADDR_COUNT  = 2'd3
    } wdt_addr_e;

    typedef enum logic {
        UNIT_SEC = 1'b0,
        UNIT_MIN = 1'b1
    } wdt_unit_e;

    // Control register layout, bit 0 is the unit select.
    typedef struct packed {
        logic      io_en;
        logic      mouse_en;
        logic      kbd_en;
        logic      rst_en;
        logic      irq_en;
        wdt_unit_e unit;
    } wdt_ctrl_t;

    localparam int CTRL_W = $bits(wdt_ctrl_t);

    typedef struct packed {
        logic io;
        logic mouse;
        logic kbd;
    } wdt_evt_t;

    function automatic logic evt_hit(input wdt_evt_t ev, input wdt_ctrl_t c);
        return (ev.kbd & c.kbd_en) | (ev.mouse & c.mouse_en) | (ev.io & c.io_en);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic              load_wr,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  load_q,
    output wdt_ctrl_t         ctrl_q,
    output logic              timeout_q
);

    logic ctrl_wr;
    logic status_wr;

    assign load_wr   = reg_wr && (wdt_addr_e'(reg_addr) == ADDR_LOAD);
    assign ctrl_wr   = reg_wr && (wdt_addr_e'(reg_addr) == ADDR_CTRL);
    assign status_wr = reg_wr && (wdt_addr_e'(reg_addr) == ADDR_STATUS);
    assign load_val  = reg_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (load_wr) load_q <= load_val;
            if (ctrl_wr) ctrl_q <= wdt_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    // Host write has priority over the counter expiry.
    always_ff @(posedge clk) begin
        if (rst)            timeout_q <= 1'b0;
        else if (status_wr) timeout_q <= reg_wdata[0];
        else if (expire)    timeout_q <= 1'b1;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (wdt_addr_e'(reg_addr))
            ADDR_LOAD:   reg_rdata[CNT_W-1:0]  = load_q;
            ADDR_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_STATUS: reg_rdata[0]          = timeout_q;
            ADDR_COUNT:  reg_rdata[CNT_W-1:0]  = count;
            default:     reg_rdata             = '0;
        endcase
    end

    a_r5_expire_sets: assert property (@(posedge clk) disable iff (rst)
        (expire && !status_wr) |=> timeout_q);

    a_r7_host_force: assert property (@(posedge clk) disable iff (rst)
        status_wr |=> (timeout_q == $past(reg_wdata[0])));

    a_r7_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (!status_wr && !expire) |=> $stable(timeout_q));

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
#(
    parameter int MIN_DIV = 60
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_tick,
    input  wdt_unit_e unit,
    input  logic      running,
    input  logic      restart,
    output logic      unit_pulse
);

    localparam int PW = (MIN_DIV > 2) ? $clog2(MIN_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(MIN_DIV - 1);

    logic [PW-1:0] pre_q;
    logic          wrap;

    assign wrap = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !running || unit == UNIT_SEC) begin
            pre_q <= '0;
        end else if (sec_tick) begin
            pre_q <= wrap ? '0 : pre_q + PW'(1);
        end
    end

    always_comb begin
        if (!running)            unit_pulse = 1'b0;
        else if (unit == UNIT_SEC) unit_pulse = sec_tick;
        else                     unit_pulse = sec_tick && wrap;
    end

    a_r4_pre_bound: assert property (@(posedge clk) disable iff (rst)
        pre_q <= PRE_LAST);

    a_r4_pre_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pre_q == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] load_q,
    input  logic             reload,
    input  logic             unit_pulse,
    output logic [CNT_W-1:0] count_q,
    output logic             running,
    output logic             expire
);

    logic reload_ok;

    assign reload_ok = reload && (load_q != '0);
    assign running   = (count_q != '0);
    assign expire    = unit_pulse && (count_q == CNT_W'(1)) && !load_wr && !reload_ok;

    always_ff @(posedge clk) begin
        if (rst)                     count_q <= '0;
        else if (load_wr)            count_q <= load_val;
        else if (reload_ok)          count_q <= load_q;
        else if (unit_pulse && running) count_q <= count_q - CNT_W'(1);
    end

    a_r5_stop_at_zero: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && !load_wr && !reload_ok) |=> (count_q == '0));

    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (running && unit_pulse && !load_wr && !reload_ok) |=> (count_q == $past(count_q) - CNT_W'(1)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!unit_pulse && !load_wr && !reload_ok) |=> $stable(count_q));

    a_r12_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_wr |=> (count_q == $past(load_val)));

endmodule

// File: rtl/lt_watchdog.sv
module lt_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int MIN_DIV = 60
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        sec_tick,
    input  logic        evt_kbd,
    input  logic        evt_mouse,
    input  logic        evt_io,
    output logic        timeout_o,
    output logic        irq_o,
    output logic        rst_o
);

    logic             load_wr;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] count_q;
    wdt_ctrl_t        ctrl_q;
    logic             timeout_q;
    logic             running;
    logic             expire;
    logic             unit_pulse;
    logic             reload;
    wdt_evt_t         evts;

    assign evts   = '{io: evt_io, mouse: evt_mouse, kbd: evt_kbd};
    assign reload = evt_hit(evts, ctrl_q);

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .count     (count_q),
        .expire    (expire),
        .load_wr   (load_wr),
        .load_val  (load_val),
        .load_q    (load_q),
        .ctrl_q    (ctrl_q),
        .timeout_q (timeout_q)
    );

    wdt_prescale #(.MIN_DIV(MIN_DIV)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .sec_tick   (sec_tick),
        .unit       (ctrl_q.unit),
        .running    (running),
        .restart    (load_wr || (reload && load_q != '0)),
        .unit_pulse (unit_pulse)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_wr    (load_wr),
        .load_val   (load_val),
        .load_q     (load_q),
        .reload     (reload),
        .unit_pulse (unit_pulse),
        .count_q    (count_q),
        .running    (running),
        .expire     (expire)
    );

    assign timeout_o = timeout_q;
    assign irq_o     = timeout_q && ctrl_q.irq_en;
    assign rst_o     = timeout_q && ctrl_q.rst_en;

    a_r10_out_gate: assert property (@(posedge clk) disable iff (rst)
        (irq_o || rst_o) |-> timeout_o);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!timeout_o && count_q == '0));

endmodule

// File: tb/lt_watchdog_bench.sv
module lt_watchdog_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd3;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0;
    logic       evt_kbd = 1'b0;
    logic       evt_mouse = 1'b0;
    logic       evt_io = 1'b0;
    logic       timeout_o, irq_o, rst_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    lt_watchdog u_lt_watchdog (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .evt_kbd(evt_kbd), .evt_mouse(evt_mouse), .evt_io(evt_io),
        .timeout_o(timeout_o), .irq_o(irq_o), .rst_o(rst_o)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input int a, input int d);
        reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 2'(a);
        #1 v = int'(reg_rdata);
        reg_addr = 2'd3;
        #1;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            sec_tick = 1'b1;
            repeat (n) @(negedge clk);
            sec_tick = 1'b0;
        end
    endtask

    task automatic pulse_evt(input int which);
        evt_kbd = (which == 0); evt_mouse = (which == 1); evt_io = (which == 2);
        @(negedge clk);
        evt_kbd = 1'b0; evt_mouse = 1'b0; evt_io = 1'b0;
    endtask

    int v;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a, v); check("R1 reg", v, 0);
        end
        check("R1 timeout", int'(timeout_o), 0);
        check("R1 irq/rst", int'(irq_o) + int'(rst_o), 0);

        // R3 R5 sweep in seconds mode
        for (int l = 1; l <= 48; l++) begin
            wr(0, l);
            rd(3, v); check("R2 loaded count", v, l);
            ticks(l - 1);
            rd(3, v); check("R3 count before expiry", v, 1);
            check("R5 flag before expiry", int'(timeout_o), 0);
            ticks(1);
            rd(3, v); check("R5 count zero", v, 0);
            check("R5 flag set", int'(timeout_o), 1);
            ticks(3);
            rd(3, v); check("R5 count stays", v, 0);
            wr(2, 0);
            check("R7 host clear", int'(timeout_o), 0);
        end
        wr(0, 255);
        ticks(254);
        rd(3, v); check("R3 max load", v, 1);
        ticks(1);
        check("R5 max load expiry", int'(timeout_o), 1);
        wr(2, 0);

        // R11 readback
        wr(1, 8'hFF);
        rd(1, v); check("R11 ctrl readback", v, 8'h3F);
        rd(0, v); check("R11 load readback", v, 255);
        wr(1, 0);

        // R6 load zero
        wr(0, 0);
        ticks(5);
        rd(3, v); check("R6 inactive count", v, 0);
        check("R6 no flag", int'(timeout_o), 0);

        // R4 minute mode
        wr(1, 8'h01);
        wr(0, 2);
        ticks(59);
        rd(3, v); check("R4 before first minute", v, 2);
        ticks(1);
        rd(3, v); check("R4 first minute", v, 1);
        ticks(60);
        rd(3, v); check("R4 second minute", v, 0);
        check("R5 minute expiry flag", int'(timeout_o), 1);
        wr(2, 0);

        // R4 prescaler cleared by reload; R8 kbd
        wr(1, 8'h09);
        wr(0, 2);
        ticks(30);
        pulse_evt(0);
        ticks(59);
        rd(3, v); check("R4 prescaler restart", v, 2);
        ticks(1);
        rd(3, v); check("R4 after restart minute", v, 1);

        // R8 R9 each event enabled and disabled, seconds mode
        for (int e = 0; e < 3; e++) begin
            wr(1, 0);
            wr(0, 10);
            ticks(4);
            pulse_evt(e);
            rd(3, v); check("R9 disabled event", v, 6);
            wr(1, 8 << e);
            pulse_evt(e);
            rd(3, v); check("R8 enabled event reload", v, 10);
            ticks(10);
            check("R8 expiry", int'(timeout_o), 1);
            pulse_evt(e);
            rd(3, v); check("R8 reload after expiry", v, 10);
            check("R8 flag untouched", int'(timeout_o), 1);
            ticks(3);
            rd(3, v); check("R8 counting again", v, 7);
            wr(2, 0);
        end

        // R7 host set while running; R10 output mapping sweep
        wr(0, 20);
        for (int c = 0; c < 4; c++) begin
            wr(1, c << 1);
            for (int s = 0; s < 2; s++) begin
                wr(2, s);
                check("R7 host set", int'(timeout_o), s);
                check("R10 irq", int'(irq_o), s & (c & 1));
                check("R10 rst", int'(rst_o), s & (c >> 1));
            end
        end
        rd(3, v); check("R7 counter unaffected", v, 20);
        wr(1, 0); wr(2, 0);

        // R7 host clear wins over same-cycle expiry
        wr(0, 1);
        sec_tick = 1'b1;
        wr(2, 0);
        sec_tick = 1'b0;
        rd(3, v); check("R7 count expired", v, 0);
        check("R7 clear beats expiry", int'(timeout_o), 0);

        // R12 load beats event beats tick
        wr(1, 8'h08);
        wr(0, 9);
        ticks(2);
        evt_kbd = 1'b1; sec_tick = 1'b1;
        wr(0, 5);
        evt_kbd = 1'b0; sec_tick = 1'b0;
        rd(3, v); check("R12 load wins", v, 5);
        ticks(2);
        evt_kbd = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        evt_kbd = 1'b0; sec_tick = 1'b0;
        rd(3, v); check("R12 event beats tick", v, 5);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got 0 expected 1 (run completed)");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule